// File: doc/BRIEF.md
# Interrupt Pending and Routing Controller

This block collects request lines from up to 26 peripherals into a sticky pending register. A per-source mask filters the pending set. A per-source mode bit then sends each surviving source to one of two active-low outputs: a fast-interrupt line or a normal-interrupt line. Software reaches the block over a single-cycle word bus. Through that bus it sets the global enables, the mode and the mask, and it reads the pending set and the lowest-numbered pending source as a one-hot word. It retires sources by writing ones to either of two clear addresses.

Four priority words are also on the bus. They are plain storage with fixed reset values, and no arbitration in the block reads them. Reads are combinational within the bus cycle. A write takes effect at the clock edge that ends its cycle.

Top module: `irq_pend_ctrl`

Register byte offsets:

| Offset | Register | Access |
|---|---|---|
| 0x00 | control, bits [2:0] | read/write |
| 0x04 | pending | read only |
| 0x08 | mode | read/write |
| 0x0C | mask | read/write |
| 0x10 to 0x1C | priority words 0 to 3 | read/write |
| 0x20 | service (one-hot) | read only |
| 0x24 | normal clear | write one to clear, reads 0 |
| 0x28 | fast clear | write one to clear, reads 0 |

## Requirements
- R1: After reset, the registers and outputs hold these values:
  - control reads 0x7, mask reads 0x03FFFFFF, and pending and mode read 0.
  - The service word reads 0.
  - Both interrupt outputs are high.
- R2: A high level on request line i sets pending bit i at the next clock edge only when control bit 1 or control bit 0 is 0. With control equal to 0x7, requests are not recorded.
- R3: A pending bit stays set after its request line returns low, until it is cleared.
- R4: Source i is active when pending bit i is 1 and mask bit i is 0. Active sources drive the outputs as follows:
  - The fast output is low when an active source has mode bit 1.
  - The normal output is low when an active source has mode bit 0.
  - Masked sources affect neither output.
  - Both outputs are registered and follow pending, mask and mode one clock later.
- R5: A write to offset 0x24 or offset 0x28 clears every pending bit whose write-data bit is 1. Write-data bits 31 to 26 have no effect.
- R6: When a request and a clear of the same bit fall in the same cycle, the bit is set after the edge.
- R7: Bus writes to the pending offset 0x04 leave the pending register unchanged.
- R8: Offset 0x20 reads a one-hot word with only the lowest-numbered pending bit set. It reads 0 when nothing is pending.
- R9: The priority words at offsets 0x10, 0x14, 0x18 and 0x1C reset to 0x1B1B1B1B, 0x00001F1B, 0x1B1B1B1B and 0x0000001B, and they read back what was written.
- R10: A read of an unmapped offset returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src | input | 26 | Peripheral request levels, bit i is source i |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fiq_n | output | 1 | Fast interrupt, active low, registered |
| irq_n | output | 1 | Normal interrupt, active low, registered |

## Verification
The following are checked on every cycle:
- Requests never set pending bits while both enables are off.
- A pending bit only ever falls on a clear write.
- A request is always recorded when latching is enabled.
- Each output equals the masked and moded reduction of the previous cycle's state.
- The service word is one-hot, is the lowest pending bit, and is nonzero whenever anything is pending.

The following can only be shown by the bench's scenarios:
- The register reset values and read-back.
- The all-ones reply at unmapped offsets.
- Which clear address accepts which data.
- The exact cycle in which an output reacts to a mask or mode write.

// File: rtl/irqc_pkg.sv
// Package: shared sizes, register offsets and reset values for the
// interrupt pending controller. Assumes byte offsets on a word bus.
package irqc_pkg;
    localparam int unsigned SRC_CNT  = 26;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OFS_W    = 8;
    localparam int unsigned PRIO_CNT = 4;

    localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_PEND   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_MODE   = 8'h08;
    localparam logic [OFS_W-1:0] OFS_MASK   = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_PRIO0  = 8'h10;
    localparam logic [OFS_W-1:0] OFS_SVC    = 8'h20;
    localparam logic [OFS_W-1:0] OFS_CLR_N  = 8'h24;
    localparam logic [OFS_W-1:0] OFS_CLR_F  = 8'h28;

    localparam logic [2:0] CTRL_RST = 3'b111;
    localparam logic [PRIO_CNT-1:0][WORD_W-1:0] PRIO_RST = {
        32'h0000001B, 32'h1B1B1B1B, 32'h00001F1B, 32'h1B1B1B1B
    };
endpackage

// File: rtl/irqc_pend_bank.sv
// Module: sticky pending register. Sets bits from request levels when
// latching is enabled and clears bits selected by a clear strobe.
// Assumes requests are synchronous to clk. A set beats a clear of the
// same bit in the same cycle.
module irqc_pend_bank #(
    parameter int unsigned N_SRC = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic             latch_en,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_bits,
    output logic [N_SRC-1:0] pend
);
    logic [N_SRC-1:0] set_v;
    logic [N_SRC-1:0] keep_v;

    // Select the bits to set and the bits that survive this cycle.
    always_comb begin
        set_v  = latch_en ? req : '0;
        keep_v = clr_en ? (pend & ~clr_bits) : pend;
    end

    // Update the pending bits; a new request overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= keep_v | set_v;
    end
endmodule

// File: rtl/irqc_route.sv
// Module: masks pending sources and splits them by mode onto two
// registered active-low outputs. Assumes a mode bit of 1 selects the
// fast output.
module irqc_route #(
    parameter int unsigned N_SRC = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] mode,
    output logic             fiq_n,
    output logic             irq_n
);
    logic [N_SRC-1:0] live_v;

    // Keep only the sources that are pending and not masked.
    always_comb live_v = pend & ~mask;

    // Register both output lines from the live set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiq_n <= 1'b1;
            irq_n <= 1'b1;
        end else begin
            fiq_n <= ~|(live_v & mode);
            irq_n <= ~|(live_v & ~mode);
        end
    end
endmodule

// File: rtl/irqc_lowest.sv
// Module: one-hot pick of the lowest set bit of a vector, built as a
// ripple of "any lower bit set" terms. Purely combinational.
module irqc_lowest #(
    parameter int unsigned N_SRC = 26
) (
    input  logic [N_SRC-1:0] vec,
    output logic [N_SRC-1:0] pick
);
    logic [N_SRC:0] lower_any;

    assign lower_any[0] = 1'b0;

    // Each bit wins only when no lower bit is set.
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        assign pick[i]        = vec[i] & ~lower_any[i];
        assign lower_any[i+1] = lower_any[i] | vec[i];
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
// Module: top of the interrupt pending controller. Holds the control,
// mode, mask and priority registers, decodes the bus and muxes read
// data. Assumes one access per cycle; reads are combinational.
module irq_pend_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC  = SRC_CNT,
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned ADDR_W = OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fiq_n,
    output logic              irq_n
);
    localparam int unsigned PAD_W = DATA_W - N_SRC;

    logic [2:0]                       ctrl_q;
    logic [N_SRC-1:0]                 mode_q;
    logic [N_SRC-1:0]                 mask_q;
    logic [N_SRC-1:0]                 pend_q;
    logic [N_SRC-1:0]                 svc_v;
    logic [PRIO_CNT-1:0][DATA_W-1:0]  prio_q;
    logic                             latch_en;
    logic                             clr_en;

    // Latching is allowed when either interrupt class is enabled.
    assign latch_en = ~ctrl_q[1] | ~ctrl_q[0];
    // Either clear offset retires pending bits.
    assign clr_en   = bus_we && (bus_addr == OFS_CLR_N || bus_addr == OFS_CLR_F);

    // Control, mode and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            mode_q <= '0;
            mask_q <= '1;
        end else if (bus_we) begin
            if (bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[2:0];
            if (bus_addr == OFS_MODE) mode_q <= bus_wdata[N_SRC-1:0];
            if (bus_addr == OFS_MASK) mask_q <= bus_wdata[N_SRC-1:0];
        end
    end

    // Priority words: plain storage at consecutive word offsets.
    for (genvar p = 0; p < PRIO_CNT; p++) begin : g_prio
        localparam logic [ADDR_W-1:0] P_OFS = OFS_PRIO0 + ADDR_W'(4 * p);
        always_ff @(posedge clk) begin
            if (!rst_n)                            prio_q[p] <= PRIO_RST[p];
            else if (bus_we && bus_addr == P_OFS)  prio_q[p] <= bus_wdata;
        end
    end

    irqc_pend_bank #(.N_SRC(N_SRC)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_src),
        .latch_en (latch_en),
        .clr_en   (clr_en),
        .clr_bits (bus_wdata[N_SRC-1:0]),
        .pend     (pend_q)
    );

    irqc_route #(.N_SRC(N_SRC)) route_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_q),
        .mask  (mask_q),
        .mode  (mode_q),
        .fiq_n (fiq_n),
        .irq_n (irq_n)
    );

    irqc_lowest #(.N_SRC(N_SRC)) low_i (
        .vec  (pend_q),
        .pick (svc_v)
    );

    // Read mux; unmapped offsets answer all ones.
    always_comb begin
        bus_rdata = '1;
        case (bus_addr)
            OFS_CTRL:           bus_rdata = {{(DATA_W-3){1'b0}}, ctrl_q};
            OFS_PEND:           bus_rdata = {{PAD_W{1'b0}}, pend_q};
            OFS_MODE:           bus_rdata = {{PAD_W{1'b0}}, mode_q};
            OFS_MASK:           bus_rdata = {{PAD_W{1'b0}}, mask_q};
            OFS_SVC:            bus_rdata = {{PAD_W{1'b0}}, svc_v};
            OFS_CLR_N, OFS_CLR_F: bus_rdata = '0;
            default: begin
                for (int p = 0; p < PRIO_CNT; p++) begin
                    if (bus_addr == OFS_PRIO0 + ADDR_W'(4 * p)) bus_rdata = prio_q[p];
                end
            end
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
// Module: protocol checker for irq_pend_ctrl, attached by bind. Watches
// the request inputs, bus strobes, register state and the outputs.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC  = SRC_CNT,
    parameter int unsigned ADDR_W = OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  irq_src,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [2:0]        ctrl,
    input logic [N_SRC-1:0]  pend,
    input logic [N_SRC-1:0]  mask,
    input logic [N_SRC-1:0]  mode,
    input logic [N_SRC-1:0]  svc,
    input logic              fiq_n,
    input logic              irq_n
);
    logic clr_wr;
    logic lat_on;
    assign clr_wr = bus_we && (bus_addr == OFS_CLR_N || bus_addr == OFS_CLR_F);
    assign lat_on = !(ctrl[1] && ctrl[0]);

    // R2: with both enables off no new pending bit appears.
    assert_no_latch_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_on) |=> ((pend & ~$past(pend)) == '0));

    // R6: an enabled request is always recorded, even against a clear.
    assert_req_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_on && |irq_src) |=> ((pend & $past(irq_src)) == $past(irq_src)));

    // R7: pending bits only fall after a clear write.
    assert_fall_only_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr) |=> (($past(pend) & ~pend) == '0));

    // R4: fast output follows last cycle's live fast-mode sources.
    assert_fiq_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_n == !(|($past(pend) & ~$past(mask) & $past(mode)))));

    // R4: normal output follows last cycle's live normal-mode sources.
    assert_irq_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == !(|($past(pend) & ~$past(mask) & ~$past(mode)))));

    // R8: service word is one-hot, pending, lowest and present when needed.
    assert_svc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc) && ((svc & ~pend) == '0));
    assert_svc_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc != '0) |-> (((svc - {{(N_SRC-1){1'b0}}, 1'b1}) & pend) == '0));
    assert_svc_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> (svc != '0));
endmodule

bind irq_pend_ctrl irqc_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_src  (irq_src),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .ctrl     (ctrl_q),
    .pend     (pend_q),
    .mask     (mask_q),
    .mode     (mode_q),
    .svc      (svc_v),
    .fiq_n    (fiq_n),
    .irq_n    (irq_n)
);

// File: tb/irq_pend_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_pend_ctrl_tb_top;
    localparam int N = 26;

    typedef struct {
        bit          is_out;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_src = '0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          fiq_n, irq_n;

    item_t sb_q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_pend_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
    );

    // Monitor: pop one expectation per falling edge and compare.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_out ? {30'b0, fiq_n, irq_n} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b0;
        sb_q.push_back('{is_out: 1'b0, exp: e, tag: tag});
        @(negedge clk);
    endtask

    // Expected {fiq_n, irq_n}.
    task automatic chk_out(input logic [1:0] e, input string tag);
        @(posedge clk); #1;
        sb_q.push_back('{is_out: 1'b1, exp: {30'b0, e}, tag: tag});
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        @(posedge clk); #1;
        irq_src = v;
        @(posedge clk); #1;
        irq_src = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 32'h7, "R1 control");
        rd(8'h0C, 32'h03FFFFFF, "R1 mask");
        rd(8'h04, 32'h0, "R1 pending");
        rd(8'h08, 32'h0, "R1 mode");
        rd(8'h20, 32'h0, "R1 service");
        chk_out(2'b11, "R1 outputs");
        // R9 priority resets and storage
        rd(8'h10, 32'h1B1B1B1B, "R9 prio0");
        rd(8'h14, 32'h00001F1B, "R9 prio1");
        rd(8'h18, 32'h1B1B1B1B, "R9 prio2");
        rd(8'h1C, 32'h0000001B, "R9 prio3");
        wr(8'h14, 32'h12345678);
        rd(8'h14, 32'h12345678, "R9 prio1 write");
        // R10 unmapped
        rd(8'hFC, 32'hFFFFFFFF, "R10 unmapped");
        rd(8'h2C, 32'hFFFFFFFF, "R10 unmapped 2C");
        // R2 both enables off
        pulse(26'h8);
        rd(8'h04, 32'h0, "R2 no latch when off");
        wr(8'h00, 32'h5);
        pulse(26'h8);
        rd(8'h04, 32'h8, "R2 latch normal enabled");
        // R3 sticky
        repeat (3) @(posedge clk);
        rd(8'h04, 32'h8, "R3 sticky");
        chk_out(2'b11, "R4 masked source silent");
        // R4 routing
        wr(8'h0C, 32'h0);
        chk_out(2'b10, "R4 normal route");
        wr(8'h08, 32'h8);
        chk_out(2'b01, "R4 fast route");
        wr(8'h08, 32'h0);
        // R8 lowest one-hot
        pulse(26'h100400);
        rd(8'h04, 32'h00100408, "R8 pending set");
        rd(8'h20, 32'h8, "R8 lowest bit3");
        wr(8'h24, 32'h8);
        rd(8'h20, 32'h400, "R8 lowest bit10");
        // R5 fast clear, upper bits harmless
        wr(8'h28, 32'hFC000400);
        rd(8'h04, 32'h00100000, "R5 fast clear");
        // R7 pending write ignored
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h00100000, "R7 pending write");
        wr(8'h24, 32'hFFFFFFFF);
        rd(8'h04, 32'h0, "R5 clear all");
        rd(8'h20, 32'h0, "R8 none pending");
        chk_out(2'b11, "R4 outputs idle");
        // R6 request beats clear
        @(posedge clk); #1;
        irq_src = 26'h20; bus_addr = 8'h24; bus_we = 1'b1; bus_wdata = 32'h20;
        @(posedge clk); #1;
        irq_src = '0; bus_we = 1'b0;
        rd(8'h04, 32'h20, "R6 request wins");
        // R2 fast-only enable also latches
        wr(8'h00, 32'h6);
        pulse(26'h2);
        rd(8'h04, 32'h22, "R2 latch fast enabled");
        rd(8'h00, 32'h6, "R1 control write");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule